// File: doc/BRIEF.md
# DMA Channel Control Register Bank and Request Arbiter

This block holds the per-channel control state of a 21-channel DMA controller and decides which channel the transfer engine serves next. Software reaches it through a small register bus. It can switch the whole controller on or off. It can enable channels and give them high priority. It can block a channel's hardware request and select the alternate descriptor or burst-only operation for a channel. These per-channel bits sit behind paired set and clear registers, so one write never disturbs the bits of other channels.

Peripherals raise level requests on `hw_req`. Software can also start channels by writing a software request register. The arbiter combines both sources, chooses one eligible channel and presents its number on the grant outputs. The engine reports the end of an arbitration burst or the end of a whole transfer. At the end of a transfer the channel is disabled, its done flag is set, and a one-cycle completion pulse goes to the peripheral unless that channel's done mask is set. An engine error flag is kept until software clears it.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every register reads 0, `grant_valid` is 0, `periph_done` is 0 and `err_irq` is 0.
- R2: Address 2 (enable set) and address 3 (enable clear) act on bit n for channel n. Writing 1 sets or clears that channel's enable. Writing 0 leaves the bit unchanged. Reading either address returns the enables.
- R3: The priority (set 4, clear 5), request-mask (set 6, clear 7), alternate-select (set 8, clear 9) and use-burst (set 10, clear 11) pairs follow the R2 rules. A priority bit of 1 means high priority.
- R4: A request-mask bit blocks the `hw_req` line of that channel and does not block a software request.
- R5: Writing address 1 makes every channel whose data bit is 1 pending by software. The request stays pending until that channel completes. Address 1 reads 0.
- R6: When no grant is held and the master enable (address 0, bit 0) is 1, the block grants an eligible channel on the next clock. A channel is eligible when it is enabled and has an unmasked hardware request or a software request. Among high-priority eligible channels the lowest number wins. If none are high priority, the lowest eligible number wins.
- R7: A held grant keeps its channel number until the engine raises `eng_burst_end` or `eng_done`. The grant then drops for one cycle, and arbitration runs again on the next clock.
- R8: `eng_done` while a grant is held clears that channel's enable and sets its done bit (address 12). Writing 1 to a done bit clears it, and a completion in the same cycle takes precedence.
- R9: One cycle after a completion, `periph_done` pulses the bit of the completed channel. No pulse appears when the done-mask bit of that channel (address 13, read/write) is 1.
- R10: While the master enable is 0, any held grant is dropped on the next clock and no new grant is issued.
- R11: `eng_err` sets an error flag seen on `err_irq` and at address 14 bit 0. Writing 1 to bit 0 of address 14 clears the flag, and a new error in the same cycle takes precedence.
- R12: While a grant is held, `grant_alt` and `grant_burst` show the alternate-select and use-burst bits of the granted channel. Without a grant both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_req | input | 21 | Level request per channel |
| eng_done | input | 1 | Engine finished the granted channel's transfer |
| eng_burst_end | input | 1 | Engine finished an arbitration burst of the granted channel |
| eng_err | input | 1 | Engine error event |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 5 | Granted channel number |
| grant_alt | output | 1 | Alternate-select bit of the granted channel |
| grant_burst | output | 1 | Use-burst bit of the granted channel |
| periph_done | output | 21 | One-cycle completion pulse per channel |
| err_irq | output | 1 | Error flag |

## Verification
The hardest state to reach is a completion of a software-started channel that has a done mask and raised priority while another channel holds the grant. A check must see that its done bit is set and that its peripheral pulse stays absent. The directed stimulus gets there in order: it enables a hardware channel, lets it hold the grant, and then sets the mask, priority and software request of a second channel. It ends the first channel's burst so that the second channel takes over, and then completes the second channel. A long random phase follows. It mixes writes to every address with engine events issued only while a grant is held, and a behavioural model is compared on every cycle.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int NCH = 21,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] hw_req,
  input  logic           eng_done,
  input  logic           eng_burst_end,
  input  logic           eng_err,
  output logic           grant_valid,
  output logic [$clog2(NCH)-1:0] grant_ch,
  output logic           grant_alt,
  output logic           grant_burst,
  output logic [NCH-1:0] periph_done,
  output logic           err_irq
);
  localparam int CW = $clog2(NCH);
  localparam int NA = 2**AW;
  localparam int A_CFG = 0, A_SWR = 1, A_ENS = 2, A_ENC = 3, A_PRS = 4, A_PRC = 5;
  localparam int A_MKS = 6, A_MKC = 7, A_ALS = 8, A_ALC = 9, A_BSS = 10, A_BSC = 11;
  localparam int A_DON = 12, A_DMK = 13, A_ERR = 14;

  logic           master, err, gv;
  logic [CW-1:0]  gch, pick;
  logic [NCH-1:0] en, pri, msk, alt, bst, dmsk, done, swp, pdone;
  logic [NCH-1:0] wd, cmp, elig, cand;
  logic [NA-1:0]  wsel;

  wire unused_wd = ^bus_wdata[DW-1:NCH];

  assign wsel = bus_wr ? (NA'(1) << bus_addr) : '0;
  assign wd   = bus_wdata[NCH-1:0];
  assign cmp  = (gv && eng_done) ? (NCH'(1) << gch) : '0;
  assign elig = en & ((hw_req & ~msk) | swp);
  assign cand = |(elig & pri) ? (elig & pri) : elig;

  function automatic logic [NCH-1:0] upd(input logic [NCH-1:0] cur,
                                         input logic s, input logic c,
                                         input logic [NCH-1:0] d);
    return (cur | (s ? d : '0)) & ~(c ? d : '0);
  endfunction

  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (cand[i]) pick = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master <= 1'b0; err <= 1'b0; gv <= 1'b0; gch <= '0;
      en <= '0; pri <= '0; msk <= '0; alt <= '0; bst <= '0;
      dmsk <= '0; done <= '0; swp <= '0; pdone <= '0;
    end else begin
      if (wsel[A_CFG]) master <= bus_wdata[0];
      if (wsel[A_DMK]) dmsk <= wd;
      en    <= upd(en & ~cmp, wsel[A_ENS], wsel[A_ENC], wd);
      pri   <= upd(pri, wsel[A_PRS], wsel[A_PRC], wd);
      msk   <= upd(msk, wsel[A_MKS], wsel[A_MKC], wd);
      alt   <= upd(alt, wsel[A_ALS], wsel[A_ALC], wd);
      bst   <= upd(bst, wsel[A_BSS], wsel[A_BSC], wd);
      swp   <= (swp & ~cmp) | (wsel[A_SWR] ? wd : '0);
      done  <= (done & ~(wsel[A_DON] ? wd : '0)) | cmp;
      err   <= (err & ~(wsel[A_ERR] & bus_wdata[0])) | eng_err;
      pdone <= cmp & ~dmsk;
      if (!master) gv <= 1'b0;
      else if (gv) begin
        if (eng_done || eng_burst_end) gv <= 1'b0;
      end else if (|cand) begin
        gv  <= 1'b1;
        gch <= pick;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_CFG:        bus_rdata[0] = master;
      A_ENS, A_ENC: bus_rdata[NCH-1:0] = en;
      A_PRS, A_PRC: bus_rdata[NCH-1:0] = pri;
      A_MKS, A_MKC: bus_rdata[NCH-1:0] = msk;
      A_ALS, A_ALC: bus_rdata[NCH-1:0] = alt;
      A_BSS, A_BSC: bus_rdata[NCH-1:0] = bst;
      A_DON:        bus_rdata[NCH-1:0] = done;
      A_DMK:        bus_rdata[NCH-1:0] = dmsk;
      A_ERR:        bus_rdata[0] = err;
      default:      bus_rdata = '0;
    endcase
  end

  assign grant_valid = gv;
  assign grant_ch    = gch;
  assign grant_alt   = gv & alt[gch];
  assign grant_burst = gv & bst[gch];
  assign periph_done = pdone;
  assign err_irq     = err;
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int NCH = 21
) (
  input logic           clk,
  input logic           rst_n,
  input logic           master,
  input logic           eng_done,
  input logic           eng_burst_end,
  input logic           eng_err,
  input logic           grant_valid,
  input logic [$clog2(NCH)-1:0] grant_ch,
  input logic [NCH-1:0] periph_done,
  input logic           err_irq
);
  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !grant_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && master && !eng_done && !eng_burst_end |=> grant_valid && $stable(grant_ch));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && (eng_done || eng_burst_end) |=> !grant_valid);

  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> int'(grant_ch) < NCH);

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_done));

  assert_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    |periph_done |-> $past(grant_valid && eng_done));

  assert_err_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(eng_err));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .eng_done(eng_done),
  .eng_burst_end(eng_burst_end), .eng_err(eng_err), .grant_valid(grant_valid),
  .grant_ch(grant_ch), .periph_done(periph_done), .err_irq(err_irq)
);

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  logic [20:0] hw_req = '0;
  logic        eng_done = 1'b0, eng_burst_end = 1'b0, eng_err = 1'b0;
  wire         grant_valid, grant_alt, grant_burst, err_irq;
  wire  [4:0]  grant_ch;
  wire  [20:0] periph_done;

  int ncmp = 0, nbad = 0, rot = 0;
  bit finished = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  dma_chan_ctl u0 (.*);

  // behavioural reference
  bit        m_master, m_err, m_gv;
  int        m_gch;
  bit [20:0] m_en, m_pri, m_msk, m_alt, m_bst, m_dmsk, m_done, m_swp, m_pd;

  function automatic int mpick();
    for (int i = 0; i < 21; i++)
      if (m_en[i] && m_pri[i] && ((hw_req[i] && !m_msk[i]) || m_swp[i])) return i;
    for (int i = 0; i < 21; i++)
      if (m_en[i] && ((hw_req[i] && !m_msk[i]) || m_swp[i])) return i;
    return -1;
  endfunction

  function automatic logic [31:0] mread(int a);
    case (a)
      0: return {31'd0, m_master};
      2, 3: return {11'd0, m_en};
      4, 5: return {11'd0, m_pri};
      6, 7: return {11'd0, m_msk};
      8, 9: return {11'd0, m_alt};
      10, 11: return {11'd0, m_bst};
      12: return {11'd0, m_done};
      13: return {11'd0, m_dmsk};
      14: return {31'd0, m_err};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(int a);
    case (a)
      0: return "R10";
      1: return "R5";
      2, 3: return "R2";
      12: return "R8";
      13: return "R9";
      14: return "R11";
      default: return (a >= 4 && a <= 11) ? "R3" : "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_master = 0; m_err = 0; m_gv = 0; m_gch = 0;
      m_en = 0; m_pri = 0; m_msk = 0; m_alt = 0; m_bst = 0;
      m_dmsk = 0; m_done = 0; m_swp = 0; m_pd = 0;
    end else begin
      bit [20:0] cmp, w, n_en, n_pri, n_msk, n_alt, n_bst, n_dmsk, n_done, n_swp;
      bit n_master, n_err;
      int pk;
      w = bus_wdata[20:0];
      cmp = (m_gv && eng_done) ? (21'd1 << m_gch) : 21'd0;
      pk = mpick();
      n_master = m_master; n_en = m_en & ~cmp; n_pri = m_pri; n_msk = m_msk;
      n_alt = m_alt; n_bst = m_bst; n_dmsk = m_dmsk; n_swp = m_swp & ~cmp;
      n_done = m_done; n_err = m_err;
      if (bus_wr) begin
        case (int'(bus_addr))
          0: n_master = bus_wdata[0];
          1: n_swp = n_swp | w;
          2: n_en = n_en | w;
          3: n_en = n_en & ~w;
          4: n_pri = n_pri | w;
          5: n_pri = n_pri & ~w;
          6: n_msk = n_msk | w;
          7: n_msk = n_msk & ~w;
          8: n_alt = n_alt | w;
          9: n_alt = n_alt & ~w;
          10: n_bst = n_bst | w;
          11: n_bst = n_bst & ~w;
          12: n_done = n_done & ~w;
          13: n_dmsk = w;
          14: if (bus_wdata[0]) n_err = 0;
          default: ;
        endcase
      end
      n_done = n_done | cmp;
      if (eng_err) n_err = 1;
      if (!m_master) m_gv = 0;
      else if (m_gv) begin
        if (eng_done || eng_burst_end) m_gv = 0;
      end else if (pk >= 0) begin
        m_gv = 1; m_gch = pk;
      end
      m_pd = cmp & ~m_dmsk;
      m_master = n_master; m_en = n_en; m_pri = n_pri; m_msk = n_msk; m_alt = n_alt;
      m_bst = n_bst; m_dmsk = n_dmsk; m_swp = n_swp; m_done = n_done; m_err = n_err;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R6 valid", {31'd0, grant_valid}, {31'd0, m_gv});
      if (m_gv) chk("R6 channel", {27'd0, grant_ch}, m_gch);
      chk("R12 alt", {31'd0, grant_alt}, {31'd0, m_gv && m_alt[m_gch]});
      chk("R12 burst", {31'd0, grant_burst}, {31'd0, m_gv && m_bst[m_gch]});
      chk("R9 pulse", {11'd0, periph_done}, {11'd0, m_pd});
      chk("R11 flag", {31'd0, err_irq}, {31'd0, m_err});
      chk(rtag(int'(bus_addr)), bus_rdata, mread(int'(bus_addr)));
    end
  end

  task automatic tick();
    @(negedge clk);
    bus_wr = 0; eng_done = 0; eng_burst_end = 0; eng_err = 0;
    bus_addr = 4'(rot % 15); rot++;
  endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    eng_done = 0; eng_burst_end = 0; eng_err = 0;
  endtask
  task automatic pulse(int k);
    @(negedge clk);
    bus_wr = 0; eng_done = (k == 0); eng_burst_end = (k == 1); eng_err = (k == 2);
  endtask
  task automatic rd(int a);
    bus_addr = 4'(a); #0.5; rv = bus_rdata;
  endtask
  task automatic settle();
    tick(); #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++; ncmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    ticks(3);
    rst_n = 1;
    settle();
    chk("R1 grant", {31'd0, grant_valid}, 0);
    chk("R1 pulse", {11'd0, periph_done}, 0);
    chk("R1 err", {31'd0, err_irq}, 0);
    rd(2); chk("R1 enables", rv, 0);
    rd(0); chk("R1 master", rv, 0);

    wreg(0, 1);
    wreg(2, (1 << 3) | (1 << 5) | (1 << 20));
    hw_req = (1 << 5) | (1 << 20);
    ticks(3); #1;
    chk("R6 lowest first", {26'd0, grant_valid, grant_ch}, {26'd0, 1'b1, 5'd5});
    wreg(4, 1 << 20);
    ticks(2); #1;
    chk("R7 held", {27'd0, grant_ch}, 5);
    pulse(1);
    ticks(2); #1;
    chk("R6 high priority", {26'd0, grant_valid, grant_ch}, {26'd0, 1'b1, 5'd20});
    pulse(0);
    settle();
    chk("R9 done pulse", {11'd0, periph_done}, 1 << 20);
    chk("R7 drop", {31'd0, grant_valid}, 0);
    settle();
    chk("R8 next grant", {27'd0, grant_ch}, 5);
    rd(2); chk("R8 enable cleared", rv, (1 << 3) | (1 << 5));
    rd(12); chk("R8 done set", rv, 1 << 20);
    wreg(12, 1 << 20);
    settle();
    rd(12); chk("R8 done w1c", rv, 0);

    wreg(13, 1 << 3);
    wreg(4, 1 << 3);
    wreg(1, 1 << 3);
    ticks(2); #1;
    chk("R7 sw waits", {27'd0, grant_ch}, 5);
    pulse(1);
    ticks(2); #1;
    chk("R5 sw grant", {26'd0, grant_valid, grant_ch}, {26'd0, 1'b1, 5'd3});
    pulse(0);
    settle();
    chk("R9 masked", {11'd0, periph_done}, 0);
    rd(12); chk("R8 masked done set", rv, 1 << 3);

    ticks(2);
    wreg(6, 1 << 5);
    pulse(1);
    ticks(3); #1;
    chk("R4 hw masked", {31'd0, grant_valid}, 0);
    wreg(1, 1 << 5);
    ticks(2); #1;
    chk("R4 sw unmasked", {26'd0, grant_valid, grant_ch}, {26'd0, 1'b1, 5'd5});
    wreg(8, 1 << 5);
    wreg(10, 1 << 5);
    settle();
    chk("R12 attributes", {30'd0, grant_alt, grant_burst}, 3);

    wreg(0, 0);
    ticks(2); #1;
    chk("R10 stopped", {31'd0, grant_valid}, 0);
    wreg(0, 1);
    pulse(2);
    settle();
    chk("R11 set", {31'd0, err_irq}, 1);
    wreg(14, 1);
    settle();
    chk("R11 cleared", {31'd0, err_irq}, 0);

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      bus_wr = 0; eng_done = 0; eng_burst_end = 0; eng_err = 0;
      bus_addr = 4'($urandom % 16);
      if ($urandom % 3 == 0) begin
        bus_wr = 1;
        bus_wdata = (bus_addr == 0) ? {31'd0, ($urandom % 8) != 0} : $urandom;
      end
      if ($urandom % 8 == 0) hw_req = 21'($urandom);
      if (grant_valid) begin
        eng_done = ($urandom % 4 == 0);
        eng_burst_end = !eng_done && ($urandom % 4 == 0);
      end
      eng_err = ($urandom % 60 == 0);
    end
    tick();
    summary();
  end
endmodule